// File: doc/BRIEF.md
# Wide-to-Narrow Register Bus Bridge

The bridge lets a requester with a wide data path reach a register bus whose data path is narrower by a whole factor. Each accepted request becomes a burst of single-cycle narrow accesses to consecutive register-bus addresses, one per chunk. On writes the held word is cut into chunks. On reads the returned chunks are gathered into one wide word. The wide side sees one request and one response per access.

Chunks always go out lowest address first, with no gaps. The registers behind the bus take a coherent snapshot on their first chunk and commit on their last. Issuing in this order keeps every wide access atomic. Any register narrower than the wide port still receives the full number of chunks. Its commit therefore happens on the final one.

The request side is a valid/ready channel. A request transfers on a cycle where both `req_valid` and `req_ready` are high. While `req_valid` waits, the requester must hold `req_we`, `req_addr` and `req_wdata` steady. `req_ready` is high only while no access is in progress, so back-pressure lasts for the whole burst. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle, and the requester must take it then.

Top module: `csr_width_bridge`

## Requirements
- R1: `req_ready` is high exactly when no access is in progress. A request transfers on a cycle with `req_valid` and `req_ready` both high.
- R2: Each accepted request produces exactly RATIO = CPU_DATA_W/CSR_DATA_W strobes. They fall on consecutive cycles, starting the cycle after acceptance, and there is no strobe outside a burst.
- R3: The strobe with chunk index i (0 first) drives `csr_addr` = `req_addr`*RATIO + i, so addresses rise by one per strobe.
- R4: On the write strobe with chunk index i, `csr_w_data` equals bits [i*CSR_DATA_W +: CSR_DATA_W] of the accepted write word.
- R5: The chunk on `csr_r_data` one cycle after the read strobe with index i is placed unchanged, zero chunks included, into bits [i*CSR_DATA_W +: CSR_DATA_W] of `rsp_rdata`.
- R6: For a write, `rsp_valid` is high for one cycle, on the cycle after the last write strobe.
- R7: For a read, `rsp_valid` is high for one cycle, two cycles after the last read strobe, with the full word on `rsp_rdata`.
- R8: `csr_r_stb` and `csr_w_stb` are never high in the same cycle.
- R9: While `rst` is high (synchronous, active high), and in the first cycle after it falls, `req_ready` is high and both strobes and `rsp_valid` are low.
- R10: Requests presented while an access is in progress are not accepted and have no effect on that access.
- R11: `req_ready` is high again in the cycle right after the `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle; request accepted when high with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | CPU_ADDR_W | Wide-word address |
| req_wdata | input | CPU_DATA_W | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | CPU_DATA_W | Assembled read word, valid with rsp_valid after a read |
| csr_addr | output | CPU_ADDR_W+log2(RATIO) | Register-bus chunk address |
| csr_r_stb | output | 1 | Read strobe |
| csr_r_data | input | CSR_DATA_W | Read chunk, valid the cycle after csr_r_stb |
| csr_w_stb | output | 1 | Write strobe |
| csr_w_data | output | CSR_DATA_W | Write chunk, valid with csr_w_stb |

## Verification
The bench builds the bridge with a 32-bit wide port, an 8-bit register bus and a 4-bit word address, so RATIO is 4 and the register space is 64 chunks. That small address space makes the top word address reachable, which exercises the highest chunk addresses. The four-chunk bursts are long enough to check ascending order, the one-cycle read lag and the little-endian placement, including zero chunks in the middle and at the edge of a word. Back-to-back requests held during a burst exercise both the back-pressure and the reopening right after the acknowledge.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_ACK   = 2'd3
  } cwb_state_e;
endpackage

// File: rtl/cwb_sequencer.sv
module cwb_sequencer
  import cwb_pkg::*;
#(
  parameter int RATIO = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_we,
  output logic             req_ready,
  output logic             take,
  output logic             issue,
  output logic             op_we,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RATIO - 1);

  cwb_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      op_we <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state <= ST_ISSUE;
            idx   <= '0;
            op_we <= req_we;
          end
        end
        ST_ISSUE: begin
          if (idx == LAST) begin
            state <= op_we ? ST_ACK : ST_DRAIN;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_DRAIN: state <= ST_ACK;
        ST_ACK:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign take      = req_ready && req_valid;
  assign issue     = (state == ST_ISSUE);
  assign done      = (state == ST_ACK);

  // A burst does not break before its final chunk
  assert_burst_unbroken_R2: assert property (@(posedge clk) disable iff (rst)
    (issue && idx != LAST) |=> issue);

  // The sequencer reopens straight after the completion cycle
  assert_reopen_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> req_ready);
endmodule

// File: rtl/cwb_wr_slicer.sv
module cwb_wr_slicer #(
  parameter int CPU_W = 32,
  parameter int CSR_W = 8,
  parameter int RATIO = 4,
  parameter int IDX_W = 2
) (
  input  logic [CPU_W-1:0] word,
  input  logic [IDX_W-1:0] sel,
  output logic [CSR_W-1:0] chunk
);
  logic [CSR_W-1:0] parts [RATIO];

  for (genvar g = 0; g < RATIO; g++) begin : g_part
    assign parts[g] = word[g*CSR_W +: CSR_W];
  end

  assign chunk = parts[sel];
endmodule

// File: rtl/cwb_rd_assembler.sv
module cwb_rd_assembler #(
  parameter int CPU_W = 32,
  parameter int CSR_W = 8,
  parameter int RATIO = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [IDX_W-1:0] slot,
  input  logic [CSR_W-1:0] chunk_in,
  output logic [CPU_W-1:0] word
);
  logic             pend;
  logic [IDX_W-1:0] pend_slot;
  logic [CSR_W-1:0] lanes [RATIO];

  // Returned data lags its strobe by one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_slot <= '0;
    end else begin
      pend      <= strobe;
      pend_slot <= slot;
    end
  end

  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lanes[g] <= '0;
      end else if (pend && pend_slot == IDX_W'(g)) begin
        lanes[g] <= chunk_in;
      end
    end
    assign word[g*CSR_W +: CSR_W] = lanes[g];
  end
endmodule

// File: rtl/csr_width_bridge.sv
module csr_width_bridge #(
  parameter int CPU_ADDR_W = 8,
  parameter int CPU_DATA_W = 32,
  parameter int CSR_DATA_W = 8,
  localparam int RATIO      = CPU_DATA_W / CSR_DATA_W,
  localparam int IDX_W      = (RATIO > 1) ? $clog2(RATIO) : 1,
  localparam int CSR_ADDR_W = CPU_ADDR_W + $clog2(RATIO)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [CPU_ADDR_W-1:0] req_addr,
  input  logic [CPU_DATA_W-1:0] req_wdata,
  output logic                  rsp_valid,
  output logic [CPU_DATA_W-1:0] rsp_rdata,
  output logic [CSR_ADDR_W-1:0] csr_addr,
  output logic                  csr_r_stb,
  input  logic [CSR_DATA_W-1:0] csr_r_data,
  output logic                  csr_w_stb,
  output logic [CSR_DATA_W-1:0] csr_w_data
);
  logic                  take, issue, op_we, done;
  logic [IDX_W-1:0]      idx;
  logic [CPU_ADDR_W-1:0] hold_addr;
  logic [CPU_DATA_W-1:0] hold_data;

  cwb_sequencer #(.RATIO(RATIO), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_ready(req_ready), .take(take), .issue(issue), .op_we(op_we),
    .idx(idx), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_addr <= '0;
      hold_data <= '0;
    end else if (take) begin
      hold_addr <= req_addr;
      hold_data <= req_wdata;
    end
  end

  cwb_wr_slicer #(.CPU_W(CPU_DATA_W), .CSR_W(CSR_DATA_W), .RATIO(RATIO), .IDX_W(IDX_W)) u_slice (
    .word(hold_data), .sel(idx), .chunk(csr_w_data)
  );

  cwb_rd_assembler #(.CPU_W(CPU_DATA_W), .CSR_W(CSR_DATA_W), .RATIO(RATIO), .IDX_W(IDX_W)) u_gather (
    .clk(clk), .rst(rst), .strobe(csr_r_stb), .slot(idx),
    .chunk_in(csr_r_data), .word(rsp_rdata)
  );

  assign csr_addr  = CSR_ADDR_W'(hold_addr) * CSR_ADDR_W'(RATIO) + CSR_ADDR_W'(idx);
  assign csr_r_stb = issue && !op_we;
  assign csr_w_stb = issue && op_we;
  assign rsp_valid = done;

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(csr_r_stb && csr_w_stb));

  assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!csr_r_stb && !csr_w_stb && !rsp_valid));

  assert_addr_ascend_R3: assert property (@(posedge clk) disable iff (rst)
    ((csr_r_stb || csr_w_stb) && ($past(csr_r_stb) || $past(csr_w_stb)))
      |-> csr_addr == $past(csr_addr) + 1'b1);

  assert_wr_ack_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(csr_w_stb) |-> rsp_valid);

  assert_rd_ack_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(csr_r_stb) |=> rsp_valid);

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sim_csr_width_bridge.sv
module sim_csr_width_bridge;
  localparam int AW  = 4;
  localparam int DW  = 32;
  localparam int CW  = 8;
  localparam int R   = DW / CW;
  localparam int CAW = AW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, csr_r_stb, csr_w_stb;
  logic [DW-1:0] rsp_rdata;
  logic [CAW-1:0] csr_addr;
  logic [CW-1:0] csr_w_data, csr_r_data;
  logic [CW-1:0] mem [2**CAW];

  csr_width_bridge #(.CPU_ADDR_W(AW), .CPU_DATA_W(DW), .CSR_DATA_W(CW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .csr_addr(csr_addr),
    .csr_r_stb(csr_r_stb), .csr_r_data(csr_r_data),
    .csr_w_stb(csr_w_stb), .csr_w_data(csr_w_data)
  );

  // Register bank behind the narrow bus: read data one cycle after strobe
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2**CAW; i++) mem[i] <= (i % 3 == 0) ? '0 : CW'(i * 13 + 1);
      csr_r_data <= '0;
    end else begin
      if (csr_r_stb) csr_r_data <= mem[csr_addr];
      if (csr_w_stb) mem[csr_addr] <= csr_w_data;
    end
  end

  int cyc = 0, n_chk = 0, n_bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // Behavioural model: one access remembered by its acceptance cycle
  bit            m_act = 0, m_we = 0, m_prev_ack = 0;
  int            m_acc = 0;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data, m_exp;

  always @(negedge clk) begin
    int off, fin;
    bit e_rd, e_wr, e_ack;
    if (!rst) begin
      off = cyc - m_acc;
      fin = m_we ? R + 1 : R + 2;
      if (m_act && off > fin) m_act = 0;
      e_rd  = m_act && !m_we && off >= 1 && off <= R;
      e_wr  = m_act &&  m_we && off >= 1 && off <= R;
      e_ack = m_act && off == fin;
      chk("R1/R10 req_ready", req_ready, !m_act);
      if (m_prev_ack) chk("R11 ready after ack", req_ready, 1);
      chk("R2 read strobe", csr_r_stb, e_rd);
      chk("R2 write strobe", csr_w_stb, e_wr);
      chk("R8 strobes exclusive", csr_r_stb && csr_w_stb, 0);
      if (e_rd || e_wr)
        chk("R3 chunk address", csr_addr, CAW'(m_addr) * CAW'(R) + CAW'(off - 1));
      if (e_wr) chk("R4 write chunk", csr_w_data, m_data[(off-1)*CW +: CW]);
      chk(m_we ? "R6 write ack" : "R7 read ack", rsp_valid, e_ack);
      if (e_ack && !m_we) chk("R5 assembled word", rsp_rdata, m_exp);
      m_prev_ack = e_ack;
      if (!m_act && req_valid) begin
        m_act = 1; m_we = req_we; m_acc = cyc;
        m_addr = req_addr; m_data = req_wdata;
        for (int i = 0; i < R; i++) m_exp[i*CW +: CW] = mem[int'(req_addr) * R + i];
      end
    end
  end

  // Holds the request until accepted; the next call presents new fields
  // while the bridge is still busy (R10)
  task automatic send(bit we, logic [AW-1:0] a, logic [DW-1:0] d);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_we    = ~we;
    req_addr  = ~a;
    req_wdata = ~d;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R9 reset ready", req_ready, 1);
    chk("R9 reset read strobe", csr_r_stb, 0);
    chk("R9 reset write strobe", csr_w_stb, 0);
    chk("R9 reset rsp_valid", rsp_valid, 0);
    @(posedge clk); #1;
    send(1, 4'd2, 32'hA1B2C3D4);
    send(0, 4'd2, 32'h5555AAAA);
    send(0, 4'd5, 32'h0);           // zero chunk inside the word (R5)
    send(1, 4'd15, 32'h00FF00FF);   // top word address (R3)
    send(0, 4'd15, 32'h12345678);
    repeat (3) @(posedge clk); #1;
    send(0, 4'd0, 32'h0);           // zero chunks at both word ends
    send(1, 4'd7, 32'hFFFFFFFF);
    send(0, 4'd7, 32'h0);
    send(1, 4'd7, 32'h00000000);
    send(0, 4'd7, 32'hDEADBEEF);
    repeat (12) @(posedge clk);
    finish_run();
  end
endmodule